// File: doc/BRIEF.md
# Table-Driven Asynchronous Memory Bus Sequencer

This block connects an internal single-request port to an external asynchronous SRAM or a similar parallel memory. The bus timing is not built into a fixed state machine. A small register table of stage commands sets it. Each entry gives:

- the level of the chip-select pin during that stage;
- the levels of the read strobe, write strobe and address-valid pins;
- for each of four byte lanes, whether the lane carries address or data, whether it drives or receives, and which byte it routes;
- how many clock cycles the stage lasts.

A request goes through a per-chip-select window compare on address bits 31:20. The window that matches supplies a first and a last table index for reads and another pair for writes. The sequencer walks that index range one stage at a time. It captures read data from the input lanes, pulses a completion, and then holds the bus idle for a fixed gap. A request that matches no window completes at once with an error flag and touches no bus pin.

Programming the table decides the bus shape. The same hardware serves an 8-bit port, a 16-bit port, or a multiplexed port where address and data share all four lanes.

Top module: `sram_cmd_engine`

## Requirements
- R1: A table write (cfg_we) stores the 20-bit stage control word cfg_ctl and a cycle count at index cfg_idx. A requested count above the largest value of the CNT_W-bit field is stored as that largest value (15 for CNT_W=4).
- R2: Each stage holds the bus for its stored cycle count. A stored count of zero lasts exactly one cycle.
- R3: The control word bits are laid out as follows, MSB first: [19] chip-select level, [18] read strobe level, [17] write strobe level, [16] address-valid level, [15:12] lane-is-data flags (bit 12+i for lane i), [11:8] lane-drives flags, [7:0] byte selectors (2 bits per lane, lane i at [2i+1:2i]). During a stage, mem_re_n and mem_we_n take the stored levels. While no stage runs, both strobes are high. The two strobes are never low together.
- R4: While a stage runs, lane i outputs byte sel_i of the write data when its data flag is set, and byte sel_i of the request address otherwise. lane_oe[i] equals the lane-drives flag while a stage runs and is 0 otherwise.
- R5: On the last cycle of any stage whose read strobe level is 0, each data lane that is not driving copies its input byte into read-data byte sel_i. Read data is cleared when a request is accepted and appears on rsp_rdata with the completion.
- R6: A request hits chip-select c when win_lo[c] <= req_addr[31:20] <= win_hi[c], with both bounds inclusive. The lowest hitting index wins. Reads run the range from rd_first[c] to rd_last[c], and writes run the range from wr_first[c] to wr_last[c].
- R7: While a stage runs, the selected chip-select pin takes the stage's level. Every other chip-select pin, and every pin while idle, sits at the inverse of its cs_on_lvl bit. At most one pin is ever at its active level.
- R8: rsp_done pulses for one cycle, in the cycle right after the last stage ends. The bus then stays idle for exactly GAP_CYC cycles (2 by default) before a waiting request's first stage appears. req_ready is low from acceptance until the gap ends.
- R9: A request that hits no window produces rsp_done with rsp_err one cycle after acceptance, and no chip-select, strobe or lane activity.
- R10: For a data lane during a stage, mem_dm[i] equals dm_on_hi of the selected chip-select when byte enable sel_i is set, and its inverse otherwise. When not a data lane, mem_dm[i] is the inactive level.
- R11: mem_adv takes the stage's address-valid level during a stage. While idle, it sits at the inverse of adv_on_lvl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | $clog2(NUM_CMDS) | Table entry index |
| cfg_ctl | input | 20 | Stage control word |
| cfg_cycles | input | REQ_CNT_W | Requested stage length, clamped on store |
| win_lo | input | NUM_CS*12 | Window lower bound per chip-select |
| win_hi | input | NUM_CS*12 | Window upper bound per chip-select |
| rd_first | input | NUM_CS*IDX_W | First read stage index per chip-select |
| rd_last | input | NUM_CS*IDX_W | Last read stage index per chip-select |
| wr_first | input | NUM_CS*IDX_W | First write stage index per chip-select |
| wr_last | input | NUM_CS*IDX_W | Last write stage index per chip-select |
| cs_on_lvl | input | NUM_CS | Active chip-select level per chip-select |
| dm_on_hi | input | NUM_CS | Byte-mask active-high select per chip-select |
| adv_on_lvl | input | 1 | Active address-valid level |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Completion had no window hit |
| rsp_rdata | output | 32 | Captured read data |
| mem_cs | output | NUM_CS | Chip-select pins |
| mem_re_n | output | 1 | Read strobe |
| mem_we_n | output | 1 | Write strobe |
| mem_adv | output | 1 | Address-valid pin |
| lane_out | output | 32 | Lane output bytes |
| lane_oe | output | 4 | Lane output enables |
| lane_in | input | 32 | Lane input bytes |
| mem_dm | output | 4 | Byte mask pins |

## Verification
Two events can share a cycle. One is the completion pulse of a finished sequence. The other is a second request that is already waiting, which must not start until the gap has passed. The bench raises the second request while the first is still on the bus and holds it. It then measures the idle bus cycles between the two chip-select bursts and compares the count with the gap. On every completion it also checks that the previous cycle was the final bus stage. A second overlap concerns the read strobe stage: its last cycle and the data capture must coincide. A bench memory model answers the lanes, and the read-back values confirm that the capture happened in that cycle with the programmed byte routing.

// File: rtl/sram_eng_pkg.sv
package sram_eng_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 32;
    localparam int WIN_W  = 12;

    typedef struct packed {
        logic       cs;
        logic       re_n;
        logic       we_n;
        logic       adv;
        logic [3:0] fn_data;
        logic [3:0] dir_out;
        logic [7:0] sel;
    } stage_ctl_t;

    localparam stage_ctl_t CTL_RESET = '{cs: 1'b0, re_n: 1'b1, we_n: 1'b1, adv: 1'b1,
                                         fn_data: 4'h0, dir_out: 4'h0, sel: 8'h00};

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

endpackage

// File: rtl/sram_cmd_table.sv
module sram_cmd_table
    import sram_eng_pkg::*;
#(
    parameter int NUM_CMDS  = 16,
    parameter int CNT_W     = 4,
    parameter int REQ_CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_CMDS)-1:0] wr_idx,
    input  stage_ctl_t                  wr_ctl,
    input  logic [REQ_CNT_W-1:0]        wr_cycles,
    input  logic [$clog2(NUM_CMDS)-1:0] rd_idx,
    output stage_ctl_t                  rd_ctl,
    output logic [CNT_W-1:0]            rd_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    stage_ctl_t         ctl_d [NUM_CMDS];
    stage_ctl_t         ctl_q [NUM_CMDS];
    logic [CNT_W-1:0]   cnt_d [NUM_CMDS];
    logic [CNT_W-1:0]   cnt_q [NUM_CMDS];
    logic [CNT_W-1:0]   clamped;

    always_comb begin
        if (wr_cycles > REQ_CNT_W'(CNT_MAX)) clamped = CNT_MAX;
        else                                 clamped = wr_cycles[CNT_W-1:0];
    end

    always_comb begin
        for (int i = 0; i < NUM_CMDS; i++) begin
            ctl_d[i] = ctl_q[i];
            cnt_d[i] = cnt_q[i];
        end
        if (wr_en) begin
            ctl_d[wr_idx] = wr_ctl;
            cnt_d[wr_idx] = clamped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CMDS; i++) begin
                ctl_q[i] <= CTL_RESET;
                cnt_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_CMDS; i++) begin
                ctl_q[i] <= ctl_d[i];
                cnt_q[i] <= cnt_d[i];
            end
        end
    end

    assign rd_ctl = ctl_q[rd_idx];
    assign rd_cnt = cnt_q[rd_idx];

endmodule

// File: rtl/sram_win_decode.sv
module sram_win_decode
    import sram_eng_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1
) (
    input  logic [WIN_W-1:0]        addr_hi,
    input  logic [NUM_CS*WIN_W-1:0] lo,
    input  logic [NUM_CS*WIN_W-1:0] hi,
    output logic                    hit,
    output logic [CS_W-1:0]         idx
);
    logic [NUM_CS-1:0] match;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        assign match[g] = (addr_hi >= lo[g*WIN_W +: WIN_W]) &&
                          (addr_hi <= hi[g*WIN_W +: WIN_W]);
    end

    always_comb begin
        idx = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) idx = CS_W'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux
    import sram_eng_pkg::*;
(
    input  logic              active,
    input  stage_ctl_t        ctl,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  logic              dm_hi,
    input  logic [DATA_W-1:0] lane_in,
    input  logic [DATA_W-1:0] rdata_cur,
    output logic [DATA_W-1:0] lane_out,
    output logic [LANES-1:0]  lane_oe,
    output logic [LANES-1:0]  dm,
    output logic [DATA_W-1:0] rdata_next
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [1:0] s;
        logic [7:0] pick;
        assign s    = ctl.sel[2*g +: 2];
        assign pick = ctl.fn_data[g] ? wdata[{s, 3'b000} +: 8] : addr[{s, 3'b000} +: 8];
        assign lane_out[8*g +: 8] = active ? pick : 8'h00;
        assign lane_oe[g] = active & ctl.dir_out[g];
        assign dm[g] = (active && ctl.fn_data[g] && be[s]) ? dm_hi : ~dm_hi;
    end

    always_comb begin
        rdata_next = rdata_cur;
        for (int i = 0; i < LANES; i++) begin
            if (ctl.fn_data[i] && !ctl.dir_out[i]) begin
                rdata_next[{ctl.sel[2*i +: 2], 3'b000} +: 8] = lane_in[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/sram_cmd_engine.sv
module sram_cmd_engine
    import sram_eng_pkg::*;
#(
    parameter int NUM_CS    = 2,
    parameter int NUM_CMDS  = 16,
    parameter int CNT_W     = 4,
    parameter int REQ_CNT_W = 16,
    parameter int GAP_CYC   = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [$clog2(NUM_CMDS)-1:0]         cfg_idx,
    input  logic [19:0]                         cfg_ctl,
    input  logic [REQ_CNT_W-1:0]                cfg_cycles,
    input  logic [NUM_CS*12-1:0]                win_lo,
    input  logic [NUM_CS*12-1:0]                win_hi,
    input  logic [NUM_CS*$clog2(NUM_CMDS)-1:0]  rd_first,
    input  logic [NUM_CS*$clog2(NUM_CMDS)-1:0]  rd_last,
    input  logic [NUM_CS*$clog2(NUM_CMDS)-1:0]  wr_first,
    input  logic [NUM_CS*$clog2(NUM_CMDS)-1:0]  wr_last,
    input  logic [NUM_CS-1:0]                   cs_on_lvl,
    input  logic [NUM_CS-1:0]                   dm_on_hi,
    input  logic                                adv_on_lvl,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_write,
    input  logic [31:0]                         req_addr,
    input  logic [31:0]                         req_wdata,
    input  logic [3:0]                          req_be,
    output logic                                rsp_done,
    output logic                                rsp_err,
    output logic [31:0]                         rsp_rdata,
    output logic [NUM_CS-1:0]                   mem_cs,
    output logic                                mem_re_n,
    output logic                                mem_we_n,
    output logic                                mem_adv,
    output logic [31:0]                         lane_out,
    output logic [3:0]                          lane_oe,
    input  logic [31:0]                         lane_in,
    output logic [3:0]                          mem_dm
);
    localparam int IDX_W = $clog2(NUM_CMDS);
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam int GAP_W = $clog2(GAP_CYC) + 1;

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   ptr;
        logic [IDX_W-1:0]   last;
        logic [CNT_W-1:0]   cnt;
        logic [GAP_W-1:0]   gap;
        logic [CS_W-1:0]    cs;
        logic               wr;
        logic [31:0]        addr;
        logic [31:0]        wdata;
        logic [3:0]         be;
        logic [31:0]        rdata;
        logic               done;
        logic               err;
    } seq_t;

    seq_t seq_d, seq_q;

    stage_ctl_t         cur_ctl;
    logic [CNT_W-1:0]   cur_cnt;
    logic [CNT_W-1:0]   stage_last;
    logic               stage_end;
    logic               active;
    logic               win_hit;
    logic [CS_W-1:0]    win_idx;
    logic [31:0]        rdata_merged;
    logic [31:0]        lane_out_w;
    logic [3:0]         lane_oe_w;
    logic [3:0]         dm_w;

    sram_cmd_table #(
        .NUM_CMDS  (NUM_CMDS),
        .CNT_W     (CNT_W),
        .REQ_CNT_W (REQ_CNT_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_ctl    (stage_ctl_t'(cfg_ctl)),
        .wr_cycles (cfg_cycles),
        .rd_idx    (seq_q.ptr),
        .rd_ctl    (cur_ctl),
        .rd_cnt    (cur_cnt)
    );

    sram_win_decode #(
        .NUM_CS (NUM_CS),
        .CS_W   (CS_W)
    ) i_win (
        .addr_hi (req_addr[31:20]),
        .lo      (win_lo),
        .hi      (win_hi),
        .hit     (win_hit),
        .idx     (win_idx)
    );

    assign active = (seq_q.phase == PH_RUN);

    sram_lane_mux i_lanes (
        .active     (active),
        .ctl        (cur_ctl),
        .addr       (seq_q.addr),
        .wdata      (seq_q.wdata),
        .be         (seq_q.be),
        .dm_hi      (dm_on_hi[seq_q.cs]),
        .lane_in    (lane_in),
        .rdata_cur  (seq_q.rdata),
        .lane_out   (lane_out_w),
        .lane_oe    (lane_oe_w),
        .dm         (dm_w),
        .rdata_next (rdata_merged)
    );

    assign stage_last = (cur_cnt == '0) ? '0 : cur_cnt - 1'b1;
    assign stage_end  = (seq_q.cnt == stage_last);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (win_hit) begin
                        seq_d.phase = PH_RUN;
                        seq_d.cs    = win_idx;
                        seq_d.wr    = req_write;
                        seq_d.addr  = req_addr;
                        seq_d.wdata = req_wdata;
                        seq_d.be    = req_be;
                        seq_d.rdata = '0;
                        seq_d.cnt   = '0;
                        seq_d.ptr   = req_write ? wr_first[int'(win_idx)*IDX_W +: IDX_W]
                                                : rd_first[int'(win_idx)*IDX_W +: IDX_W];
                        seq_d.last  = req_write ? wr_last[int'(win_idx)*IDX_W +: IDX_W]
                                                : rd_last[int'(win_idx)*IDX_W +: IDX_W];
                    end else begin
                        seq_d.phase = PH_GAP;
                        seq_d.gap   = '0;
                        seq_d.done  = 1'b1;
                        seq_d.err   = 1'b1;
                    end
                end
            end
            PH_RUN: begin
                if (stage_end) begin
                    if (!cur_ctl.re_n) seq_d.rdata = rdata_merged;
                    seq_d.cnt = '0;
                    if (seq_q.ptr == seq_q.last) begin
                        seq_d.phase = PH_GAP;
                        seq_d.gap   = '0;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.ptr = seq_q.ptr + 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                if (seq_q.gap == GAP_W'(GAP_CYC - 2)) seq_d.phase = PH_IDLE;
                else                                  seq_d.gap   = seq_q.gap + 1'b1;
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            if (active && (seq_q.cs == CS_W'(i))) mem_cs[i] = cur_ctl.cs;
            else                                   mem_cs[i] = ~cs_on_lvl[i];
        end
    end

    assign mem_re_n  = active ? cur_ctl.re_n : 1'b1;
    assign mem_we_n  = active ? cur_ctl.we_n : 1'b1;
    assign mem_adv   = active ? cur_ctl.adv  : ~adv_on_lvl;
    assign lane_out  = lane_out_w;
    assign lane_oe   = lane_oe_w;
    assign mem_dm    = active ? dm_w : {4{~dm_on_hi[seq_q.cs]}};
    assign req_ready = (seq_q.phase == PH_IDLE);
    assign rsp_done  = seq_q.done;
    assign rsp_err   = seq_q.err;
    assign rsp_rdata = seq_q.rdata;

endmodule

// File: rtl/sram_cmd_engine_chk.sv
module sram_cmd_engine_chk #(
    parameter int NUM_CS  = 2,
    parameter int GAP_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [NUM_CS-1:0] mem_cs,
    input logic [NUM_CS-1:0] cs_on_lvl,
    input logic              mem_re_n,
    input logic              mem_we_n,
    input logic [3:0]        lane_oe
);
    logic [NUM_CS-1:0] cs_act;
    logic [15:0]       gap_ctr;
    logic              seen_done;

    assign cs_act = ~(mem_cs ^ cs_on_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_ctr   <= '0;
            seen_done <= 1'b0;
        end else if (rsp_done) begin
            gap_ctr   <= 16'd1;
            seen_done <= 1'b1;
        end else if (!req_ready) begin
            gap_ctr   <= gap_ctr + 16'd1;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_re_n && !mem_we_n)); // R3

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_re_n && mem_we_n && (lane_oe == 4'h0) && (cs_act == '0))); // R8

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8

    AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_ready) && seen_done) |-> (gap_ctr == 16'(GAP_CYC - 1))); // R8

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done); // R9

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($past(req_ready) && (cs_act == '0))); // R9

    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_act) <= 1); // R7

endmodule

bind sram_cmd_engine sram_cmd_engine_chk #(
    .NUM_CS  (NUM_CS),
    .GAP_CYC (GAP_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .mem_cs    (mem_cs),
    .cs_on_lvl (cs_on_lvl),
    .mem_re_n  (mem_re_n),
    .mem_we_n  (mem_we_n),
    .lane_oe   (lane_oe)
);

// File: tb/test_sram_cmd_engine.sv
module test_sram_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [19:0] cfg_ctl = '0;
    logic [15:0] cfg_cycles = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] lane_in = '0;
    logic        req_ready, rsp_done, rsp_err, mem_re_n, mem_we_n, mem_adv;
    logic [31:0] rsp_rdata, lane_out;
    logic [1:0]  mem_cs;
    logic [3:0]  lane_oe, mem_dm;

    localparam logic [1:0] CS_ON = 2'b10;

    always #2.5 clk = ~clk;

    sram_cmd_engine i_sram_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_ctl(cfg_ctl),
        .cfg_cycles(cfg_cycles), .win_lo({12'h002, 12'h001}), .win_hi({12'h003, 12'h002}),
        .rd_first({4'd8, 4'd0}), .rd_last({4'd11, 4'd3}),
        .wr_first({4'd12, 4'd4}), .wr_last({4'd15, 4'd7}),
        .cs_on_lvl(CS_ON), .dm_on_hi(2'b01), .adv_on_lvl(1'b0),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs(mem_cs), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n), .mem_adv(mem_adv),
        .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in), .mem_dm(mem_dm)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model answering the lanes
    logic [7:0]  mem8  [logic [23:0]];
    logic [31:0] mem32 [logic [31:0]];
    logic [31:0] mux_a = '0;

    always @(negedge clk) begin
        if (mem_cs[0] == CS_ON[0]) begin
            if (!mem_we_n && mem_dm[0]) mem8[lane_out[31:8]] = lane_out[7:0];
            lane_in <= {24'h0, mem8.exists(lane_out[31:8]) ? mem8[lane_out[31:8]] : 8'h00};
        end else if (mem_cs[1] == CS_ON[1]) begin
            logic [31:0] w;
            if (!mem_adv) mux_a = lane_out;
            w = mem32.exists(mux_a) ? mem32[mux_a] : 32'h0;
            if (!mem_we_n) begin
                for (int i = 0; i < 4; i++) if (!mem_dm[i]) w[8*i +: 8] = lane_out[8*i +: 8];
                mem32[mux_a] = w;
            end
            lane_in <= w;
        end
    end

    // scoreboard monitor and bus counters
    typedef struct { bit err; bit wr; logic [31:0] rd; } exp_t;
    exp_t sb_q[$];

    int cs0_cyc, cs1_cyc, re_lo, we_lo, adv_lo, idle_run, gap_seen;
    logic [31:0] snap_out;
    logic [3:0]  snap_oe, snap_dm, snap_re_oe;
    bit prev_act = 1'b0;

    always @(negedge clk) begin
        logic [1:0] act;
        act = ~(mem_cs ^ CS_ON);
        if (rst_n && rsp_done) begin
            if (sb_q.size() == 0) chk(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rsp_err == e.err, e.err ? "R9" : "R6", "error flag", 32'(rsp_err), 32'(e.err));
                if (!e.err && !e.wr) chk(rsp_rdata == e.rd, "R5", "read data", rsp_rdata, e.rd);
                if (!e.err) chk(prev_act && (act == 2'b00), "R8", "done after final stage",
                                32'(prev_act), 32'd1);
            end
        end
        if (|act) begin
            if (!prev_act) begin
                gap_seen = idle_run;
                cs0_cyc = 0; cs1_cyc = 0; re_lo = 0; we_lo = 0; adv_lo = 0;
            end
            idle_run = 0;
            if (act[0]) cs0_cyc++;
            if (act[1]) cs1_cyc++;
            if (!mem_re_n) begin re_lo++; snap_re_oe = lane_oe; end
            if (!mem_we_n) begin we_lo++; snap_out = lane_out; snap_oe = lane_oe; snap_dm = mem_dm; end
            if (!mem_adv) adv_lo++;
        end else begin
            idle_run++;
        end
        prev_act = |act;
    end

    function automatic logic [19:0] mk(input bit cs, re_n, we_n, adv,
                                       input logic [3:0] fn, dir, input logic [7:0] sel);
        return {cs, re_n, we_n, adv, fn, dir, sel};
    endfunction

    task automatic prog(input int idx, input logic [19:0] c, input int cyc);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_ctl = c; cfg_cycles = 16'(cyc);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input bit wr, input logic [31:0] a, d, input logic [3:0] be,
                         input bit exp_err, input logic [31:0] exp_rd, input bit wait_done);
        exp_t e;
        e.err = exp_err; e.wr = wr; e.rd = exp_rd;
        sb_q.push_back(e);
        if (wait_done) begin
            cs0_cyc = 0; cs1_cyc = 0; re_lo = 0; we_lo = 0; adv_lo = 0;
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wait_done) while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: R3 R7 R8 R11
        chk(req_ready == 1'b1, "R8", "ready after reset", 32'(req_ready), 32'd1);
        chk(mem_re_n && mem_we_n, "R3", "strobes idle", {mem_re_n, mem_we_n}, 32'd3);
        chk(mem_cs == 2'b01, "R7", "cs idle levels", 32'(mem_cs), 32'd1);
        chk(mem_adv == 1'b1, "R11", "adv idle", 32'(mem_adv), 32'd1);
        chk(lane_oe == 4'h0 && !rsp_done, "R4", "lanes idle", 32'(lane_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // cs0: 8-bit port, lane0 data, lanes 1..3 address bytes 0..2
        prog(0, mk(0, 1, 1, 1, 4'b0001, 4'b1110, 8'h90), 2);
        prog(1, mk(0, 1, 1, 1, 4'b0001, 4'b1110, 8'h90), 1);
        prog(2, mk(0, 0, 1, 1, 4'b0001, 4'b1110, 8'h90), 3);
        prog(3, mk(0, 1, 1, 1, 4'b0001, 4'b1110, 8'h90), 0);
        prog(4, mk(0, 1, 1, 1, 4'b0001, 4'b1111, 8'h90), 1);
        prog(5, mk(0, 1, 1, 1, 4'b0001, 4'b1111, 8'h90), 1);
        prog(6, mk(0, 1, 0, 1, 4'b0001, 4'b1111, 8'h90), 100);
        prog(7, mk(0, 1, 1, 1, 4'b0001, 4'b1111, 8'h90), 1);
        // cs1: multiplexed, all lanes address then data
        prog(8,  mk(1, 1, 1, 0, 4'b0000, 4'b1111, 8'hE4), 2);
        prog(9,  mk(1, 1, 1, 1, 4'b0000, 4'b1111, 8'hE4), 1);
        prog(10, mk(1, 0, 1, 1, 4'b1111, 4'b0000, 8'hE4), 2);
        prog(11, mk(1, 1, 1, 1, 4'b1111, 4'b0000, 8'hE4), 1);
        prog(12, mk(1, 1, 1, 0, 4'b0000, 4'b1111, 8'hE4), 1);
        prog(13, mk(1, 1, 1, 1, 4'b0000, 4'b1111, 8'hE4), 1);
        prog(14, mk(1, 1, 0, 1, 4'b1111, 4'b1111, 8'hE4), 2);
        prog(15, mk(1, 1, 1, 1, 4'b1111, 4'b1111, 8'hE4), 1);

        issue(1'b1, 32'h0010_0034, 32'h0000_00A5, 4'b0001, 1'b0, 32'h0, 1'b1);
        chk(we_lo == 15, "R1", "clamped write strobe length", 32'(we_lo), 32'd15);
        chk(cs0_cyc == 18, "R2", "write sequence length", 32'(cs0_cyc), 32'd18);
        chk(snap_out == 32'h1000_34A5, "R4", "8-bit lane routing", snap_out, 32'h1000_34A5);
        chk(snap_oe == 4'b1111, "R4", "write lane enables", 32'(snap_oe), 32'hF);
        chk(snap_dm[0] == 1'b1, "R10", "mask active high", 32'(snap_dm), 32'h1);

        issue(1'b0, 32'h0010_0034, 32'h0, 4'b0001, 1'b0, 32'h0000_00A5, 1'b1);
        chk(re_lo == 3, "R2", "read strobe length", 32'(re_lo), 32'd3);
        chk(cs0_cyc == 7, "R2", "read length with zero-count stage", 32'(cs0_cyc), 32'd7);
        chk(snap_re_oe == 4'b1110, "R4", "read lane enables", 32'(snap_re_oe), 32'hE);
        chk(cs1_cyc == 0, "R7", "other cs quiet", 32'(cs1_cyc), 32'd0);

        issue(1'b1, 32'h0010_0034, 32'h0000_003C, 4'b0000, 1'b0, 32'h0, 1'b1);
        chk(snap_dm[0] == 1'b0, "R10", "disabled byte mask", 32'(snap_dm), 32'h0);
        issue(1'b0, 32'h0010_0034, 32'h0, 4'b0001, 1'b0, 32'h0000_00A5, 1'b1);

        issue(1'b1, 32'h0020_0010, 32'h0000_0077, 4'b0001, 1'b0, 32'h0, 1'b1);
        chk(cs0_cyc == 18 && cs1_cyc == 0, "R6", "overlap picks lowest index",
            32'(cs1_cyc), 32'd0);
        issue(1'b0, 32'h0020_0010, 32'h0, 4'b0001, 1'b0, 32'h0000_0077, 1'b1);

        issue(1'b1, 32'h0030_0100, 32'h1122_3344, 4'b1111, 1'b0, 32'h0, 1'b1);
        chk(adv_lo == 1, "R11", "adv only in setup (write)", 32'(adv_lo), 32'd1);
        chk(cs1_cyc == 5, "R7", "cs1 active length", 32'(cs1_cyc), 32'd5);
        chk(snap_out == 32'h1122_3344, "R4", "mux data lanes", snap_out, 32'h1122_3344);
        chk(snap_dm == 4'b0000, "R10", "mask active low", 32'(snap_dm), 32'h0);

        issue(1'b0, 32'h0030_0100, 32'h0, 4'b1111, 1'b0, 32'h1122_3344, 1'b1);
        chk(adv_lo == 2, "R11", "adv only in setup (read)", 32'(adv_lo), 32'd2);

        issue(1'b1, 32'h003F_FFFC, 32'hDEAD_BEEF, 4'b0101, 1'b0, 32'h0, 1'b1);
        chk(snap_dm == 4'b1010, "R10", "partial mask low", 32'(snap_dm), 32'hA);
        issue(1'b0, 32'h003F_FFFC, 32'h0, 4'b1111, 1'b0, 32'h00AD_00EF, 1'b1);
        chk(cs1_cyc == 6, "R6", "upper bound inclusive", 32'(cs1_cyc), 32'd6);

        issue(1'b0, 32'h0050_0000, 32'h0, 4'b1111, 1'b1, 32'h0, 1'b1);
        chk(cs0_cyc == 0 && cs1_cyc == 0 && re_lo == 0, "R9", "miss leaves bus quiet",
            32'(cs0_cyc + cs1_cyc), 32'd0);
        issue(1'b1, 32'h000F_FFFF, 32'h0, 4'b1111, 1'b1, 32'h0, 1'b1);
        chk(cs0_cyc == 0 && cs1_cyc == 0 && we_lo == 0, "R9", "miss below windows",
            32'(cs0_cyc + cs1_cyc), 32'd0);

        // back-to-back: second request waits through the gap
        issue(1'b0, 32'h0010_0034, 32'h0, 4'b0001, 1'b0, 32'h0000_00A5, 1'b0);
        issue(1'b0, 32'h0020_0010, 32'h0, 4'b0001, 1'b0, 32'h0000_0077, 1'b1);
        chk(gap_seen == 2, "R8", "idle gap between transactions", 32'(gap_seen), 32'd2);
        chk(mem_re_n && mem_we_n && mem_cs == 2'b01, "R3", "bus idle at end",
            32'(mem_cs), 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule